// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Arbiter

This block finds, separately for every CPU interface, the most urgent interrupt that is both enabled and pending for that CPU. It publishes that interrupt's ID and drives the CPU's interrupt request line. The block is a pure selector. The register file, the acknowledge and completion logic and the storage of the enable, pending and priority state all sit outside it. They present that state as flat vectors on the ports.

The search runs as a repeating sweep. Each clock cycle examines one window of `SLICE` consecutive interrupt IDs, starting from ID 0, and keeps a running best candidate per CPU. After `NSTEP = NUM_IRQ / SLICE` cycles the sweep ends. On that publish edge each CPU's winner is compared with two thresholds. The CPU's priority mask decides whether the winner is reported at all. The CPU's running priority decides whether the request line is raised.

Top module: `pend_arbiter`

## Requirements
- R1: Among the candidates of one CPU, the one with the numerically smallest 8-bit priority wins. Priorities are packed as `prioVec[id*8 +: 8]`.
- R2: When candidates have equal priority, the one with the lowest interrupt ID wins, including when they lie in different scan windows.
- R3: When a CPU has no candidate, its published ID is 1023 and its request line is low.
- R4: An interrupt is a candidate for CPU `c` only when both `enVec[id*NUM_CPU+c]` and `pendVec[id*NUM_CPU+c]` are 1. A bit set for another CPU has no effect on `c`.
- R5: The winner's ID is published only when its priority is strictly below the CPU's mask (`prioMask[c*8 +: 8]`). An equal or larger priority publishes 1023 with the line low.
- R6: The request line is high only when a winner is published and its priority is strictly below the CPU's running priority (`runPrio[c*9 +: 9]`). The value 0x100 there means idle.
- R7: While `distEn` is 0, every CPU publishes 1023 with its line low.
- R8: While `cpuEn[c]` is 0, CPU `c` publishes 1023 with its line low. Other CPUs are unaffected.
- R9: Outputs change only on a publish edge, which occurs once every `NSTEP` cycles. After a state change, the outputs reflect the new state no later than `2*NSTEP` cycles later.
- R10: During and directly after reset, every CPU shows ID 1023 with its line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| distEn | input | 1 | Global distributor enable |
| cpuEn | input | NUM_CPU | Per-CPU interface enable |
| enVec | input | NUM_IRQ*NUM_CPU | Enable bit per interrupt and CPU, bit id*NUM_CPU+cpu |
| pendVec | input | NUM_IRQ*NUM_CPU | Pending bit per interrupt and CPU, bit id*NUM_CPU+cpu |
| prioVec | input | NUM_IRQ*8 | Priority of each interrupt |
| prioMask | input | NUM_CPU*8 | Priority mask of each CPU |
| runPrio | input | NUM_CPU*9 | Running priority of each CPU, 0x100 when idle |
| hpId | output | NUM_CPU*10 | Highest-pending ID of each CPU, 1023 for none |
| irqOut | output | NUM_CPU | Interrupt request line of each CPU |

## Verification
The thresholds are read on the publish edge itself, so a change to an enable, mask or running priority shows up within `NSTEP` cycles. A change to a pending, enable or priority bit can land just after its window was scanned, so it can take up to `2*NSTEP` cycles to appear. The bench drives every stimulus on a falling edge and then waits `2*NSTEP+1` rising edges before it samples on a falling edge. Every comparison therefore sees a complete sweep over stable inputs. The reset check samples before the first sweep ends, while the reset values still stand.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
  localparam logic [8:0] IDLE_RUN = 9'h100;

  typedef struct packed {
    logic clearBest;  // first window of a sweep: restart the search
    logic publish;    // last window of a sweep: register the result
  } arbStrb_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NSTEP  = 4,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [STEP_W-1:0] stepIdx,
  output arbStrb_t          strb
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (stepIdx == LAST_STEP) begin
      stepIdx <= '0;
    end else begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  always_comb begin
    strb.clearBest = (stepIdx == '0);
    strb.publish   = (stepIdx == LAST_STEP);
  end
endmodule

// File: rtl/arb_lane.sv
module arb_lane
  import arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int SLICE   = 16,
  parameter int CPU_IDX = 0,
  parameter int STEP_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  arbStrb_t                   strb,
  input  logic [STEP_W-1:0]          stepIdx,
  input  logic [NUM_IRQ*NUM_CPU-1:0] enVec,
  input  logic [NUM_IRQ*NUM_CPU-1:0] pendVec,
  input  logic [NUM_IRQ*8-1:0]       prioVec,
  input  logic                       gateOn,
  input  logic [7:0]                 maskPrio,
  input  logic [8:0]                 runPrio,
  output logic [ID_W-1:0]            hpId,
  output logic                       irqLine
);
  logic [8:0]      bestPrio, scanPrio;
  logic [ID_W-1:0] bestId, scanId;

  // Ascending scan with strict compare: ties keep the lower ID.
  always_comb begin
    scanPrio = strb.clearBest ? IDLE_RUN : bestPrio;
    scanId   = strb.clearBest ? NONE_ID  : bestId;
    for (int j = 0; j < SLICE; j++) begin
      int idx;
      int bitPos;
      idx    = int'(stepIdx) * SLICE + j;
      bitPos = idx * NUM_CPU + CPU_IDX;
      if (enVec[bitPos] && pendVec[bitPos] &&
          ({1'b0, prioVec[idx*8 +: 8]} < scanPrio)) begin
        scanPrio = {1'b0, prioVec[idx*8 +: 8]};
        scanId   = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestPrio <= IDLE_RUN;
      bestId   <= NONE_ID;
      hpId     <= NONE_ID;
      irqLine  <= 1'b0;
    end else begin
      bestPrio <= scanPrio;
      bestId   <= scanId;
      if (strb.publish) begin
        if (gateOn && (scanPrio < {1'b0, maskPrio})) begin
          hpId    <= scanId;
          irqLine <= (scanPrio < runPrio);
        end else begin
          hpId    <= NONE_ID;
          irqLine <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/arb_dp.sv
module arb_dp
  import arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int SLICE   = 16,
  parameter int STEP_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  arbStrb_t                   strb,
  input  logic [STEP_W-1:0]          stepIdx,
  input  logic                       distEn,
  input  logic [NUM_CPU-1:0]         cpuEn,
  input  logic [NUM_IRQ*NUM_CPU-1:0] enVec,
  input  logic [NUM_IRQ*NUM_CPU-1:0] pendVec,
  input  logic [NUM_IRQ*8-1:0]       prioVec,
  input  logic [NUM_CPU*8-1:0]       prioMask,
  input  logic [NUM_CPU*9-1:0]       runPrio,
  output logic [NUM_CPU*ID_W-1:0]    hpId,
  output logic [NUM_CPU-1:0]         irqOut
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
    logic gateOn;
    assign gateOn = distEn & cpuEn[c];

    arb_lane #(
      .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SLICE(SLICE),
      .CPU_IDX(c), .STEP_W(STEP_W)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .stepIdx (stepIdx),
      .enVec   (enVec),
      .pendVec (pendVec),
      .prioVec (prioVec),
      .gateOn  (gateOn),
      .maskPrio(prioMask[c*8 +: 8]),
      .runPrio (runPrio[c*9 +: 9]),
      .hpId    (hpId[c*ID_W +: ID_W]),
      .irqLine (irqOut[c])
    );
  end
endmodule

// File: rtl/pend_arbiter.sv
module pend_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int SLICE   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       distEn,
  input  logic [NUM_CPU-1:0]         cpuEn,
  input  logic [NUM_IRQ*NUM_CPU-1:0] enVec,
  input  logic [NUM_IRQ*NUM_CPU-1:0] pendVec,
  input  logic [NUM_IRQ*8-1:0]       prioVec,
  input  logic [NUM_CPU*8-1:0]       prioMask,
  input  logic [NUM_CPU*9-1:0]       runPrio,
  output logic [NUM_CPU*10-1:0]      hpId,
  output logic [NUM_CPU-1:0]         irqOut
);
  localparam int NSTEP  = NUM_IRQ / SLICE;
  localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  arbStrb_t          strb;
  logic [STEP_W-1:0] stepIdx;
  logic              pubStrb;

  assign pubStrb = strb.publish;

  arb_ctrl #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stepIdx(stepIdx),
    .strb   (strb)
  );

  arb_dp #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SLICE(SLICE), .STEP_W(STEP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stepIdx (stepIdx),
    .distEn  (distEn),
    .cpuEn   (cpuEn),
    .enVec   (enVec),
    .pendVec (pendVec),
    .prioVec (prioVec),
    .prioMask(prioMask),
    .runPrio (runPrio),
    .hpId    (hpId),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int SLICE   = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  distEn,
  input logic [NUM_CPU-1:0]    cpuEn,
  input logic [NUM_CPU*10-1:0] hpId,
  input logic [NUM_CPU-1:0]    irqOut,
  input logic                  pubStrb
);
  localparam int NSTEP = NUM_IRQ / SLICE;
  int sincePub;

  always_ff @(posedge clk) begin
    if (!rstN) sincePub <= 0;
    else if (pubStrb) sincePub <= 0;
    else sincePub <= sincePub + 1;
  end

  // R9
  publish_cadence_chk: assert property (@(posedge clk) disable iff (!rstN)
    sincePub < NSTEP);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // R6
    irq_needs_id_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> (hpId[c*10 +: 10] != 10'd1023));
    // R7
    dist_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pubStrb && !distEn) |=> (!irqOut[c] && hpId[c*10 +: 10] == 10'd1023));
    // R8
    cpu_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pubStrb && !cpuEn[c]) |=> (!irqOut[c] && hpId[c*10 +: 10] == 10'd1023));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !pubStrb |=> ($stable(hpId[c*10 +: 10]) && $stable(irqOut[c])));
    // R3
    id_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hpId[c*10 +: 10] == 10'd1023) || (int'(hpId[c*10 +: 10]) < NUM_IRQ));
  end
endmodule

bind pend_arbiter arb_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SLICE(SLICE)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .distEn (distEn),
  .cpuEn  (cpuEn),
  .hpId   (hpId),
  .irqOut (irqOut),
  .pubStrb(pubStrb)
);

// File: tb/sim_pend_arbiter.sv
module sim_pend_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int SL = 16;
  localparam int NSTEP = NI / SL;
  localparam int SETTLE = 2 * NSTEP + 1;

  // {aId, aPrio, bId, bPrio, mask, run, expId, expIrq} for CPU 0
  localparam logic [63:0] VEC [6] = '{
    {10'd5,  8'h40, 10'd9,  8'h20, 8'hFF, 9'h100, 10'd9,    1'b1},  // R1
    {10'd3,  8'h30, 10'd40, 8'h30, 8'hFF, 9'h100, 10'd3,    1'b1},  // R2
    {10'd60, 8'h10, 10'd2,  8'h50, 8'hFF, 9'h010, 10'd60,   1'b0},  // R6 equal run
    {10'd7,  8'h60, 10'd8,  8'h70, 8'h60, 9'h100, 10'd1023, 1'b0},  // R5 equal mask
    {10'd7,  8'h60, 10'd7,  8'h60, 8'h61, 9'h061, 10'd7,    1'b1},  // R5 R6 just below
    {10'd63, 8'h00, 10'd0,  8'h00, 8'hFF, 9'h100, 10'd0,    1'b1}   // R2 across windows
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic distEn;
  logic [NC-1:0] cpuEn;
  logic [NI*NC-1:0] enVec, pendVec;
  logic [NI*8-1:0] prioVec;
  logic [NC*8-1:0] prioMask;
  logic [NC*9-1:0] runPrio;
  logic [NC*10-1:0] hpId;
  logic [NC-1:0] irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pend_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC), .SLICE(SL)) u0 (
    .clk(clk), .rstN(rstN), .distEn(distEn), .cpuEn(cpuEn),
    .enVec(enVec), .pendVec(pendVec), .prioVec(prioVec),
    .prioMask(prioMask), .runPrio(runPrio), .hpId(hpId), .irqOut(irqOut)
  );

  task automatic clearAll();
    enVec = '0; pendVec = '0;
    for (int i = 0; i < NI; i++) prioVec[i*8 +: 8] = 8'h80;
    prioMask = {NC{8'hFF}};
    runPrio = {NC{9'h100}};
    distEn = 1'b1;
    cpuEn = '1;
  endtask

  task automatic setCand(input int cpu, input int id, input logic [7:0] p);
    enVec[id*NC+cpu] = 1'b1;
    pendVec[id*NC+cpu] = 1'b1;
    prioVec[id*8 +: 8] = p;
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkCpu(input int cpu, input logic [9:0] expId,
                          input logic expIrq, input string req);
    checks++;
    if (hpId[cpu*10 +: 10] !== expId || irqOut[cpu] !== expIrq) begin
      errors++;
      $display("FAIL %s cpu%0d id=%0d irq=%0b expected id=%0d irq=%0b",
               req, cpu, hpId[cpu*10 +: 10], irqOut[cpu], expId, expIrq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearAll();
    setCand(0, 4, 8'h10);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCpu(0, 10'd1023, 1'b0, "R10");
    rstN = 1'b1;
    @(negedge clk);
    checkCpu(0, 10'd1023, 1'b0, "R10");
    checkCpu(1, 10'd1023, 1'b0, "R10");

    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      clearAll();
      setCand(0, int'(VEC[v][63:54]), VEC[v][53:46]);
      setCand(0, int'(VEC[v][45:36]), VEC[v][35:28]);
      prioMask[7:0] = VEC[v][27:20];
      runPrio[8:0] = VEC[v][19:11];
      settle();
      checkCpu(0, VEC[v][10:1], VEC[v][0], $sformatf("R1/R2/R5/R6 vec%0d", v));
      checkCpu(1, 10'd1023, 1'b0, "R3");
    end

    // R4: enable for cpu0 and pending for cpu1 only
    clearAll();
    enVec[10*NC+0] = 1'b1;
    pendVec[10*NC+1] = 1'b1;
    prioVec[10*8 +: 8] = 8'h20;
    settle();
    checkCpu(0, 10'd1023, 1'b0, "R4");
    checkCpu(1, 10'd1023, 1'b0, "R4");
    enVec[10*NC+1] = 1'b1;
    settle();
    checkCpu(1, 10'd10, 1'b1, "R4");
    checkCpu(0, 10'd1023, 1'b0, "R4");

    // R7: distributor off
    clearAll();
    setCand(0, 12, 8'h10);
    setCand(1, 33, 8'h10);
    distEn = 1'b0;
    settle();
    checkCpu(0, 10'd1023, 1'b0, "R7");
    checkCpu(1, 10'd1023, 1'b0, "R7");

    // R8: only cpu1 interface off
    distEn = 1'b1;
    cpuEn = 2'b01;
    settle();
    checkCpu(0, 10'd12, 1'b1, "R8");
    checkCpu(1, 10'd1023, 1'b0, "R8");

    // R9: a new more urgent interrupt in the last window appears within the bound
    cpuEn = 2'b11;
    settle();
    checkCpu(1, 10'd33, 1'b1, "R9");
    setCand(1, 62, 8'h05);
    settle();
    checkCpu(1, 10'd62, 1'b1, "R9");

    // R3: nothing pending at all
    clearAll();
    settle();
    checkCpu(0, 10'd1023, 1'b0, "R3");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule